// File: doc/BRIEF.md
# Stream Buffer FIFO with Occupancy Flags

This block is a single-clock first-in first-out buffer for one point-to-point data stream. A producer pushes words through a write strobe and watches a space flag. A consumer pops words through a read strobe and watches a data flag. The buffer also reports how many words it holds and raises a flag once it is at least half occupied, so that a host can service it in batches instead of word by word.

The depth, the word width and two build options are parameters. The first option picks the read path. In the combinational variant the oldest word is always on the read data port. In the registered variant the popped word is captured into an output register on the pop edge. The second option, a guard mode, turns a push into a full buffer and a pop from an empty one into no-ops. A one-entry depth is built as a single register with a valid bit. The buffer empties either through a synchronous clear strobe or through an active-low asynchronous reset.

Top module: `strm_fifo`

## Requirements
- R1: `DEPTH` must be a power of two from 1 to 32768, and any other value stops elaboration. The buffer holds exactly `DEPTH` words.
- R2: While `rst_n` is low, without waiting for a clock edge, `level` is 0, `rd_avail` is 0, `wr_free` is 1 and `half` is 0. In the registered read variant `rd_data` is 0.
- R3: A high `clr` at a rising edge empties the buffer at that edge. It takes priority over a push or a pop in the same cycle. Words pushed afterwards are read back normally.
- R4: `wr_free` is 1 exactly when `level` is below `DEPTH`.
- R5: `rd_avail` is 1 exactly when `level` is above 0.
- R6: `half` is 1 exactly when `level` is at least ceil(`DEPTH`/2). With `DEPTH` = 1 it therefore equals `rd_avail`.
- R7: `level` counts the stored words. After an accepted push alone it is one higher at the next edge, and after an accepted pop alone it is one lower.
- R8: Words leave in the order they entered. In the combinational read variant `rd_data` shows the oldest stored word whenever `rd_avail` is 1.
- R9: In the registered read variant, the popped word appears on `rd_data` at the edge that accepts the pop. Otherwise `rd_data` holds its value.
- R10: A push and a pop in the same cycle, while the buffer is neither full nor empty, both take effect and leave `level` unchanged.
- R11: With `GUARD` = 1, a push while full is dropped and a pop while empty is dropped. The stored words, their order and `rd_data` are unchanged. The other strobe of the same cycle still takes effect.
- R12: With `DEPTH` = 1 the buffer holds one word. It is full after a single push and empty after a single pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous empty strobe, active high |
| wr_data | input | WIDTH | Word to push |
| wr_en | input | 1 | Push strobe |
| wr_free | output | 1 | At least one slot is empty |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | WIDTH | Oldest word, or the last popped word in the registered variant |
| rd_avail | output | 1 | At least one word is stored |
| level | output | clog2(DEPTH)+1 | Number of stored words |
| half | output | 1 | Occupancy is at least ceil(DEPTH/2) |

## Verification
On every cycle the assertions check how the flags relate to the occupancy count, that the count never exceeds the depth, the clear, the unchanged count on a simultaneous push and pop, and, in guard mode, that a full or empty buffer does not wrap. They also check that the registered output holds when no pop occurs. Word ordering, the exact words that appear on the read port, the asynchronous action of the reset between edges, and the behaviour of the one-entry and registered variants can only be shown by the bench's scenarios. The bench runs these on three instances with different build options.

// File: rtl/strm_fifo_pkg.sv
package strm_fifo_pkg;

   // true when v is a positive power of two
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // address bits needed for d slots, never below one
   function automatic int unsigned slot_bits(input int unsigned d);
      return (d > 1) ? $clog2(d) : 1;
   endfunction

   // occupancy at which the half flag rises: ceil(d/2)
   function automatic int unsigned half_mark(input int unsigned d);
      return (d + 1) / 2;
   endfunction

endpackage

// File: rtl/strm_fifo_ctrl.sv
module strm_fifo_ctrl
   import strm_fifo_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter bit          GUARD = 1'b1,
   parameter int unsigned AW    = slot_bits(DEPTH),
   parameter int unsigned LW    = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          wr_go,
   output logic          rd_go,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic [LW-1:0] level,
   output logic          free,
   output logic          avail,
   output logic          half
);

   localparam int unsigned HALF_AT = half_mark(DEPTH);

   // accepted strobes: guard mode blocks illegal accesses
   assign wr_go = wr_en & (free  | ~GUARD);
   assign rd_go = rd_en & (avail | ~GUARD);

   generate
      if (DEPTH == 1) begin : g_single
         logic valid_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     valid_q <= 1'b0;
            else if (clr)   valid_q <= 1'b0;
            else if (wr_go) valid_q <= 1'b1;
            else if (rd_go) valid_q <= 1'b0;
         end

         assign waddr = '0;
         assign raddr = '0;
         assign level = valid_q;
         assign free  = ~valid_q;
         assign avail = valid_q;
         assign half  = valid_q;
      end else begin : g_multi
         logic [AW:0] wptr_q, rptr_q;   // one wrap bit above the slot address
         logic [LW-1:0] occ;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wptr_q <= '0;
               rptr_q <= '0;
            end else if (clr) begin
               wptr_q <= '0;
               rptr_q <= '0;
            end else begin
               if (wr_go) wptr_q <= wptr_q + 1'b1;
               if (rd_go) rptr_q <= rptr_q + 1'b1;
            end
         end

         assign occ   = LW'(wptr_q - rptr_q);
         assign waddr = wptr_q[AW-1:0];
         assign raddr = rptr_q[AW-1:0];
         assign level = occ;
         assign free  = !((wptr_q[AW] != rptr_q[AW]) && (waddr == raddr));
         assign avail = (wptr_q != rptr_q);
         assign half  = (occ >= LW'(HALF_AT));
      end
   endgenerate

   // ---------------- assertions ----------------
   a_r4_free_level: assert property (@(posedge clk) disable iff (!rst_n)
      free == (level < LW'(DEPTH)));

   a_r5_avail_level: assert property (@(posedge clk) disable iff (!rst_n)
      avail == (level != '0));

   a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   a_r6_half_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      half |-> avail);

   a_r6_full_is_half: assert property (@(posedge clk) disable iff (!rst_n)
      !free |-> half);

   a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0));

   a_r10_rw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && free && avail && !clr) |=> $stable(level));

   generate
      if (GUARD) begin : g_guard_chk
         a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (!free && wr_en && !rd_en && !clr) |=> !free);

         a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            (!avail && rd_en && !wr_en && !clr) |=> !avail);
      end
   endgenerate

endmodule

// File: rtl/strm_fifo_mem.sv
module strm_fifo_mem #(
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned WIDTH    = 32,
   parameter int unsigned AW       = 3,
   parameter bit          READ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] slot_q [DEPTH];
   logic [WIDTH-1:0] head;

   always_ff @(posedge clk) begin
      if (we) slot_q[waddr] <= wdata;
   end

   assign head = slot_q[raddr];

   generate
      if (READ_REG) begin : g_reg_read
         logic [WIDTH-1:0] out_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  out_q <= '0;
            else if (re) out_q <= head;
         end

         assign rdata = out_q;

         a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !re |=> $stable(rdata));
      end else begin : g_comb_read
         assign rdata = head;
      end
   endgenerate

   a_r8_write_known: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> !$isunknown(waddr));

endmodule

// File: rtl/strm_fifo.sv
module strm_fifo
   import strm_fifo_pkg::*;
#(
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned WIDTH    = 32,
   parameter bit          READ_REG = 1'b0,
   parameter bit          GUARD    = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic [WIDTH-1:0]       wr_data,
   input  logic                   wr_en,
   output logic                   wr_free,
   input  logic                   rd_en,
   output logic [WIDTH-1:0]       rd_data,
   output logic                   rd_avail,
   output logic [$clog2(DEPTH):0] level,
   output logic                   half
);

   localparam int unsigned AW = slot_bits(DEPTH);
   localparam int unsigned LW = $clog2(DEPTH) + 1;

   // R1: elaboration-time parameter checks
   generate
      if (!is_pow2(DEPTH) || DEPTH > 32768) begin : g_bad_depth
         $error("strm_fifo: DEPTH must be a power of two in 1..32768");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("strm_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic          wr_go, rd_go;
   logic [AW-1:0] waddr, raddr;

   strm_fifo_ctrl #(
      .DEPTH (DEPTH),
      .GUARD (GUARD),
      .AW    (AW),
      .LW    (LW)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .wr_en (wr_en & ~clr),
      .rd_en (rd_en & ~clr),
      .wr_go (wr_go),
      .rd_go (rd_go),
      .waddr (waddr),
      .raddr (raddr),
      .level (level),
      .free  (wr_free),
      .avail (rd_avail),
      .half  (half)
   );

   strm_fifo_mem #(
      .DEPTH    (DEPTH),
      .WIDTH    (WIDTH),
      .AW       (AW),
      .READ_REG (READ_REG)
   ) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_go),
      .waddr (waddr),
      .wdata (wr_data),
      .re    (rd_go),
      .raddr (raddr),
      .rdata (rd_data)
   );

   a_r12_single_full: assert property (@(posedge clk) disable iff (!rst_n)
      (DEPTH == 1 && rd_avail) |-> !wr_free);

endmodule

// File: tb/sim_strm_fifo.sv
module sim_strm_fifo;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 15;

   typedef struct packed {
      logic        wr;
      logic        rd;
      logic        cl;
      logic [15:0] d;
      logic [2:0]  lvl;
      logic        av;
      logic        fr;
      logic        hf;
      logic [15:0] hd;
      logic [3:0]  req;
   } vec_t;

   // stimulus and expected state after the edge, for the DEPTH=4 combinational instance
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b0,16'hA001,3'd1,1'b1,1'b1,1'b0,16'hA001,4'd7 },  // R7 push
      '{1'b1,1'b0,1'b0,16'hA002,3'd2,1'b1,1'b1,1'b1,16'hA001,4'd6 },  // R6 half rises at 2
      '{1'b1,1'b1,1'b0,16'hA003,3'd2,1'b1,1'b1,1'b1,16'hA002,4'd10},  // R10 push+pop
      '{1'b1,1'b0,1'b0,16'hA004,3'd3,1'b1,1'b1,1'b1,16'hA002,4'd8 },  // R8 order
      '{1'b1,1'b0,1'b0,16'hA005,3'd4,1'b1,1'b0,1'b1,16'hA002,4'd4 },  // R4 full, R1 capacity
      '{1'b1,1'b0,1'b0,16'hA006,3'd4,1'b1,1'b0,1'b1,16'hA002,4'd11},  // R11 push dropped
      '{1'b1,1'b1,1'b0,16'hA007,3'd3,1'b1,1'b1,1'b1,16'hA003,4'd11},  // R11 push dropped, pop taken
      '{1'b0,1'b1,1'b0,16'h0000,3'd2,1'b1,1'b1,1'b1,16'hA004,4'd8 },  // R8
      '{1'b0,1'b1,1'b0,16'h0000,3'd1,1'b1,1'b1,1'b0,16'hA005,4'd6 },  // R6 half falls
      '{1'b0,1'b1,1'b0,16'h0000,3'd0,1'b0,1'b1,1'b0,16'h0000,4'd5 },  // R5 empty
      '{1'b0,1'b1,1'b0,16'h0000,3'd0,1'b0,1'b1,1'b0,16'h0000,4'd11},  // R11 pop dropped
      '{1'b1,1'b1,1'b0,16'hB001,3'd1,1'b1,1'b1,1'b0,16'hB001,4'd11},  // R11 pop dropped, push taken
      '{1'b1,1'b0,1'b0,16'hB002,3'd2,1'b1,1'b1,1'b1,16'hB001,4'd7 },  // R7
      '{1'b1,1'b1,1'b1,16'hB003,3'd0,1'b0,1'b1,1'b0,16'h0000,4'd3 },  // R3 clear wins
      '{1'b1,1'b0,1'b0,16'hB004,3'd1,1'b1,1'b1,1'b0,16'hB004,4'd3 }   // R3 reuse after clear
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] wd = '0;

   logic        fr0, av0, hf0;
   logic [15:0] rd0;
   logic [2:0]  lv0;
   logic        fr1, av1, hf1;
   logic [15:0] rd1;
   logic [0:0]  lv1;
   logic        fr2, av2, hf2;
   logic [15:0] rd2;
   logic [2:0]  lv2;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strm_fifo #(.DEPTH(4), .WIDTH(16), .READ_REG(1'b0), .GUARD(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_data(wd), .wr_en(wr_en), .wr_free(fr0),
      .rd_en(rd_en), .rd_data(rd0), .rd_avail(av0), .level(lv0), .half(hf0));

   strm_fifo #(.DEPTH(1), .WIDTH(16), .READ_REG(1'b0), .GUARD(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_data(wd), .wr_en(wr_en), .wr_free(fr1),
      .rd_en(rd_en), .rd_data(rd1), .rd_avail(av1), .level(lv1), .half(hf1));

   strm_fifo #(.DEPTH(4), .WIDTH(16), .READ_REG(1'b1), .GUARD(1'b1)) u2 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_data(wd), .wr_en(wr_en), .wr_free(fr2),
      .rd_en(rd_en), .rd_data(rd2), .rd_avail(av2), .level(lv2), .half(hf2));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic step(input logic w, input logic r, input logic c, input logic [15:0] d);
      wr_en = w; rd_en = r; clr = c; wd = d;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; clr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // reset state, R2
      #(CLK_PERIOD/4);
      chk("R2 level in reset", 32'(lv0), 32'd0);
      chk("R2 avail in reset", 32'(av0), 32'd0);
      chk("R2 free in reset",  32'(fr0), 32'd1);
      chk("R2 half in reset",  32'(hf0), 32'd0);
      chk("R2 registered rd_data in reset", 32'(rd2), 32'd0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table, DEPTH=4 combinational instance (R1 capacity checked at vector 4)
      for (int i = 0; i < NV; i++) begin
         step(VECS[i].wr, VECS[i].rd, VECS[i].cl, VECS[i].d);
         n_run++;
         if (lv0 !== VECS[i].lvl || av0 !== VECS[i].av || fr0 !== VECS[i].fr ||
             hf0 !== VECS[i].hf || (VECS[i].av && rd0 !== VECS[i].hd)) begin
            n_fail++;
            $display("FAIL R%0d vec %0d actual lvl=%0d av=%b fr=%b hf=%b hd=%h expected lvl=%0d av=%b fr=%b hf=%b hd=%h",
                     VECS[i].req, i, lv0, av0, fr0, hf0, rd0,
                     VECS[i].lvl, VECS[i].av, VECS[i].fr, VECS[i].hf, VECS[i].hd);
         end
      end

      // R2: asynchronous reset acts between edges
      rst_n = 1'b0;
      #2;
      chk("R2 async level", 32'(lv0), 32'd0);
      chk("R2 async avail", 32'(av0), 32'd0);
      chk("R2 async free",  32'(fr0), 32'd1);
      chk("R2 async registered rd_data", 32'(rd2), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 single entry (u1) and R9 registered read (u2), same stimulus
      step(1'b1, 1'b0, 1'b0, 16'hC001);
      chk("R12 depth1 level after push", 32'(lv1), 32'd1);
      chk("R12 depth1 full after push",  32'(fr1), 32'd0);
      chk("R6 depth1 half equals avail", 32'(hf1), 32'd1);
      chk("R12 depth1 data",             32'(rd1), 32'hC001);
      chk("R9 registered holds without pop", 32'(rd2), 32'd0);

      step(1'b1, 1'b0, 1'b0, 16'hC002);
      chk("R11 depth1 push while full dropped", 32'(rd1), 32'hC001);
      chk("R12 depth1 level stays 1", 32'(lv1), 32'd1);
      chk("R7 registered level 2", 32'(lv2), 32'd2);

      step(1'b0, 1'b1, 1'b0, 16'h0000);
      chk("R12 depth1 empty after pop", 32'(av1), 32'd0);
      chk("R6 depth1 half clears",      32'(hf1), 32'd0);
      chk("R9 registered pop shows first word", 32'(rd2), 32'hC001);

      step(1'b0, 1'b0, 1'b0, 16'h0000);
      chk("R9 registered holds when idle", 32'(rd2), 32'hC001);

      step(1'b0, 1'b1, 1'b0, 16'h0000);
      chk("R9 registered second pop", 32'(rd2), 32'hC002);
      chk("R5 registered empty", 32'(av2), 32'd0);

      step(1'b0, 1'b1, 1'b0, 16'h0000);
      chk("R11 registered pop on empty ignored", 32'(rd2), 32'hC002);
      chk("R11 level stays 0", 32'(lv2), 32'd0);

      finish_run();
   end

endmodule